// File: doc/BRIEF.md
# Event Timer Shared Control and Status

This block is the common section of a multi-channel event timer. It owns a free-running 32-bit tick counter, a read-only capability descriptor, a read-only tick-period register and a global configuration register that holds a run enable and a legacy routing select. It also keeps one pending bit per comparator channel, which software clears by writing ones. Each comparator channel presents a match pulse, its trigger type and the number of the interrupt line it wants to drive. The block turns these into a vector of interrupt lines.

Software reaches the registers through a 32-bit request/response port with valid/ready handshakes on both sides. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A read returns exactly one response. Writes return nothing. `req_ready` is low while a read response is waiting and `rsp_ready` is low. While the response is stalled in this way, `rsp_valid` and `rsp_data` hold steady. The counter advances by one each clock while the run enable is set and stands still while it is clear.

Register word addresses on `req_addr`: 0 capabilities, 1 tick period, 2 configuration, 3 pending status, 4 counter.

Top module: `evt_timer_global`

## Requirements
- R1: A read of address 0 returns the capability word. Bits 7:0 hold the revision, bits 12:8 hold the channel count minus one, bit 13 (counter-size flag) reads 0 for a 32-bit counter, bit 15 holds the legacy-capable flag and bits 31:16 hold the vendor ID. The defaults give 32'hA55A_8301, or 32'hA55A_0301 when not legacy-capable.
- R2: A read of address 1 returns the tick period in femtoseconds. It is a nonzero constant: 50,000,000 (32'h02FA_F080) by default, which is a 20 MHz tick.
- R3: Bit 0 of the configuration register (address 2) is the run enable. While it is set, the counter gains one per clock. While it is clear, the counter keeps its value.
- R4: A write to address 4 loads the counter only while the run enable is clear. While the enable is set, the write is ignored.
- R5: Bit 1 of the configuration register is the legacy-route select. It can be written only when the legacy-capable flag is set; otherwise it reads as 0 and has no effect on routing.
- R6: A match on a level-triggered channel (`ch_level` = 1) sets that channel's bit in the status register (address 3) on the next edge. The bit stays set until it is cleared, and the channel's line is asserted for as long as the bit is set.
- R7: A write to address 3 clears each status bit written as 1 and leaves each bit written as 0 unchanged. A match and a clearing write on the same edge leave the bit set.
- R8: A match on an edge-triggered channel (`ch_level` = 0) drives its routed line high for exactly one clock, starting the edge after the match, and sets no status bit.
- R9: With legacy routing in effect, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields say. Other channels follow their route fields, and a route field at or beyond the line count drives no line.
- R10: A read accepted on an edge presents `rsp_valid` and its data after that edge. `req_ready` is low while a response waits on `rsp_ready`, and the response holds steady until it is taken.
- R11: Reads of addresses 5 to 7 return 0. Writes to the read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Requester takes the read data |
| rsp_data | output | 32 | Read data |
| ch_match | input | NUM_CH | Per-channel comparator match pulse |
| ch_level | input | NUM_CH | Per-channel trigger type, 1 = level |
| ch_route | input | NUM_CH*ROUTE_W | Per-channel line number, channel 0 in the low field |
| irq_line | output | NUM_LINES | Interrupt line outputs |

## Verification
Every result has a fixed latency. A read's data and `rsp_valid` appear after the edge that accepts it. A status bit, a level line and an edge pulse all appear after the edge that samples the match, and the edge pulse is gone one edge later. A configuration or counter write first shows in the counter on the edge after the write edge. The bench drives inputs on falling edges and samples at the following falling edge, so each check lands one edge after its cause. Counter checks compare the difference between two reads with the number of edges between their accepting edges. This avoids predicting absolute counts.

// File: rtl/evtg_pkg.sv
package evtg_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CAPS   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] A_CONFIG = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;

  localparam int unsigned CFG_RUN_BIT = 0;
  localparam int unsigned CFG_LEG_BIT = 1;

  // Fixed legacy line numbers taken over by channels 0 and 1.
  localparam int unsigned LEG_LINE_A = 0;
  localparam int unsigned LEG_LINE_B = 8;

  function automatic logic [DATA_W-1:0] caps_word(
    input logic [15:0] vendor,
    input logic        leg_cap,
    input int unsigned n_ch,
    input logic [7:0]  rev
  );
    logic [DATA_W-1:0] w;
    w        = '0;
    w[7:0]   = rev;
    w[12:8]  = 5'(n_ch - 1);
    w[13]    = 1'b0;
    w[15]    = leg_cap;
    w[31:16] = vendor;
    return w;
  endfunction
endpackage

// File: rtl/evtg_counter.sv
module evtg_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (run) begin
      count <= count + CNT_W'(1);
    end else if (load) begin
      count <= load_val;
    end
  end
endmodule

// File: rtl/evtg_status.sv
module evtg_status #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] match,
  input  logic [NUM_CH-1:0] level,
  input  logic              clr_stb,
  input  logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] sts,
  output logic [NUM_CH-1:0] ch_int
);
  logic [NUM_CH-1:0] pulse_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic set_i;
    logic clr_i;
    assign set_i = match[i] & level[i];
    assign clr_i = clr_stb & clr_mask[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sts[i]     <= 1'b0;
        pulse_q[i] <= 1'b0;
      end else begin
        sts[i]     <= set_i | (sts[i] & ~clr_i);
        pulse_q[i] <= match[i] & ~level[i];
      end
    end

    assign ch_int[i] = sts[i] | pulse_q[i];
  end
endmodule

// File: rtl/evtg_router.sv
module evtg_router #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned ROUTE_W   = 5
) (
  input  logic [NUM_CH-1:0]         ch_int,
  input  logic [NUM_CH*ROUTE_W-1:0] ch_route,
  input  logic                      legacy,
  output logic [NUM_LINES-1:0]      lines
);
  import evtg_pkg::*;

  always_comb begin
    lines = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      logic [ROUTE_W-1:0] r;
      r = ch_route[c*ROUTE_W +: ROUTE_W];
      if (legacy && c == 0) begin
        lines[LEG_LINE_A] = lines[LEG_LINE_A] | ch_int[c];
      end else if (legacy && c == 1) begin
        lines[LEG_LINE_B] = lines[LEG_LINE_B] | ch_int[c];
      end else if (int'(r) < NUM_LINES) begin
        lines[r] = lines[r] | ch_int[c];
      end
    end
  end
endmodule

// File: rtl/evt_timer_global.sv
module evt_timer_global #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned ROUTE_W   = 5,
  parameter logic [7:0]  REV_ID    = 8'h01,
  parameter logic [15:0] VENDOR_ID = 16'hA55A,
  parameter logic [31:0] PERIOD_FS = 32'd50_000_000,
  parameter logic        LEG_CAP   = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [2:0]                req_addr,
  input  logic [31:0]               req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [31:0]               rsp_data,
  input  logic [NUM_CH-1:0]         ch_match,
  input  logic [NUM_CH-1:0]         ch_level,
  input  logic [NUM_CH*ROUTE_W-1:0] ch_route,
  output logic [NUM_LINES-1:0]      irq_line
);
  import evtg_pkg::*;

  localparam logic [DATA_W-1:0] CAPS = caps_word(VENDOR_ID, LEG_CAP, NUM_CH, REV_ID);

  logic              accept, wr_stb, rd_stb;
  logic              cfg_en_q, cfg_leg_q;
  logic              cnt_load, sts_clr;
  logic [DATA_W-1:0] cnt_q;
  logic [NUM_CH-1:0] sts_q, ch_int;
  logic [DATA_W-1:0] sts_word, rd_mux;

  assign req_ready = ~rsp_valid | rsp_ready;
  assign accept    = req_valid & req_ready;
  assign wr_stb    = accept & req_write;
  assign rd_stb    = accept & ~req_write;
  assign cnt_load  = wr_stb && (req_addr == A_COUNT);
  assign sts_clr   = wr_stb && (req_addr == A_STATUS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en_q  <= 1'b0;
      cfg_leg_q <= 1'b0;
    end else if (wr_stb && req_addr == A_CONFIG) begin
      cfg_en_q  <= req_wdata[CFG_RUN_BIT];
      cfg_leg_q <= LEG_CAP & req_wdata[CFG_LEG_BIT];
    end
  end

  evtg_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(cfg_en_q), .load(cnt_load),
    .load_val(req_wdata), .count(cnt_q)
  );

  evtg_status #(.NUM_CH(NUM_CH)) u_sts (
    .clk(clk), .rst_n(rst_n), .match(ch_match), .level(ch_level),
    .clr_stb(sts_clr), .clr_mask(req_wdata[NUM_CH-1:0]),
    .sts(sts_q), .ch_int(ch_int)
  );

  evtg_router #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES), .ROUTE_W(ROUTE_W)) u_rte (
    .ch_int(ch_int), .ch_route(ch_route), .legacy(cfg_leg_q), .lines(irq_line)
  );

  always_comb begin
    sts_word = '0;
    sts_word[NUM_CH-1:0] = sts_q;
    case (req_addr)
      A_CAPS:   rd_mux = CAPS;
      A_PERIOD: rd_mux = PERIOD_FS;
      A_CONFIG: rd_mux = {30'd0, cfg_leg_q, cfg_en_q};
      A_STATUS: rd_mux = sts_word;
      A_COUNT:  rd_mux = cnt_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_stb) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/evtg_checker.sv
module evtg_checker #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned NUM_LINES = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_en,
  input logic                 cfg_leg,
  input logic [31:0]          cnt,
  input logic                 cnt_load,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [31:0]          rsp_data,
  input logic [NUM_CH-1:0]    sts,
  input logic                 clr_stb,
  input logic [NUM_CH-1:0]    clr_mask,
  input logic [NUM_CH-1:0]    ch_match,
  input logic [NUM_CH-1:0]    ch_level,
  input logic [NUM_CH-1:0]    ch_int,
  input logic [NUM_LINES-1:0] irq_line
);
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !cnt_load) |=> $stable(cnt));

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cnt == $past(cnt) + 32'd1);

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r9_legacy_a: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_leg && ch_int[0]) |-> irq_line[0]);

  a_r9_legacy_b: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_leg && ch_int[1]) |-> irq_line[8]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[i] && !(clr_stb && clr_mask[i])) |=> sts[i]);

    a_r8_no_status: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_match[i] && !ch_level[i] && !sts[i]) |=> !sts[i]);
  end
endmodule

bind evt_timer_global evtg_checker #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en_q), .cfg_leg(cfg_leg_q),
  .cnt(cnt_q), .cnt_load(cnt_load), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .sts(sts_q), .clr_stb(sts_clr),
  .clr_mask(req_wdata[NUM_CH-1:0]), .ch_match(ch_match), .ch_level(ch_level),
  .ch_int(ch_int), .irq_line(irq_line)
);

// File: tb/evt_timer_global_test.sv
module evt_timer_global_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  ch_match = '0, ch_level = '0;
  logic [19:0] ch_route = {5'd12, 5'd10, 5'd5, 5'd3};
  logic        req_ready, rsp_valid, req_ready_nc, rsp_valid_nc;
  logic [31:0] rsp_data, rsp_data_nc;
  logic [23:0] irq_line, irq_line_nc;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  evt_timer_global uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ch_match(ch_match), .ch_level(ch_level), .ch_route(ch_route), .irq_line(irq_line)
  );

  evt_timer_global #(.LEG_CAP(1'b0)) uut_nc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_nc),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid_nc), .rsp_ready(rsp_ready), .rsp_data(rsp_data_nc),
    .ch_match(ch_match), .ch_level(ch_level), .ch_route(ch_route), .irq_line(irq_line_nc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [31:0] d, output logic [31:0] dnc);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data; dnc = rsp_data_nc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d, dn;
    chk("R10 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R10 reset req_ready", {31'd0, req_ready}, 32'd1);
    chk("R6 reset lines", {8'd0, irq_line}, 32'd0);
    do_read(3'd2, d, dn);
    chk("R10 read latency", {31'd0, rsp_valid}, 32'd1);
    chk("R3 reset config", d, 32'd0);
  endtask

  task automatic t_ident();
    logic [31:0] d, dn;
    do_read(3'd0, d, dn);
    chk("R1 caps", d, 32'hA55A_8301);
    chk("R1 caps no-legacy", dn, 32'hA55A_0301);
    do_read(3'd1, d, dn);
    chk("R2 period", d, 32'h02FA_F080);
    do_write(3'd0, 32'h0);
    do_write(3'd1, 32'h0);
    do_read(3'd0, d, dn);
    chk("R11 caps after write", d, 32'hA55A_8301);
    do_read(3'd1, d, dn);
    chk("R11 period after write", d, 32'h02FA_F080);
    do_read(3'd7, d, dn);
    chk("R11 unmapped 7", d, 32'd0);
    do_read(3'd5, d, dn);
    chk("R11 unmapped 5", d, 32'd0);
  endtask

  task automatic t_counter();
    logic [31:0] a, b, c, dn;
    do_read(3'd4, a, dn);
    idle(3);
    do_read(3'd4, b, dn);
    chk("R3 frozen at reset", b, a);
    do_write(3'd4, 32'd1000);
    do_read(3'd4, a, dn);
    chk("R4 load while stopped", a, 32'd1000);
    do_write(3'd2, 32'd1);
    do_read(3'd4, a, dn);
    idle(4);
    do_read(3'd4, b, dn);
    chk("R3 advance per clock", b - a, 32'd5);
    do_write(3'd4, 32'd0);
    do_read(3'd4, c, dn);
    chk("R4 load ignored while running", c - b, 32'd2);
    do_write(3'd2, 32'd0);
    do_read(3'd4, a, dn);
    idle(3);
    do_read(3'd4, b, dn);
    chk("R3 frozen after stop", b, a);
  endtask

  task automatic t_level();
    logic [31:0] d, dn;
    ch_level[2] = 1'b1; ch_match[2] = 1'b1;
    @(negedge clk);
    ch_match[2] = 1'b0;
    chk("R6 level line set", {31'd0, irq_line[10]}, 32'd1);
    idle(3);
    chk("R6 level line held", {31'd0, irq_line[10]}, 32'd1);
    do_read(3'd3, d, dn);
    chk("R6 status bit", d, 32'd4);
    do_write(3'd3, 32'd0);
    do_read(3'd3, d, dn);
    chk("R7 zero write keeps", d, 32'd4);
    do_write(3'd3, 32'hB);
    do_read(3'd3, d, dn);
    chk("R7 other bits keep", d, 32'd4);
    do_write(3'd3, 32'd4);
    chk("R7 line drops on clear", {31'd0, irq_line[10]}, 32'd0);
    do_read(3'd3, d, dn);
    chk("R7 cleared", d, 32'd0);
    ch_match[2] = 1'b1;
    do_write(3'd3, 32'd4);
    ch_match[2] = 1'b0;
    do_read(3'd3, d, dn);
    chk("R7 set wins over clear", d, 32'd4);
    do_write(3'd3, 32'hF);
    do_read(3'd3, d, dn);
    chk("R7 all-ones clear", d, 32'd0);
  endtask

  task automatic t_edge();
    logic [31:0] d, dn;
    ch_level[3] = 1'b0; ch_match[3] = 1'b1;
    @(negedge clk);
    ch_match[3] = 1'b0;
    chk("R8 edge pulse high", {31'd0, irq_line[12]}, 32'd1);
    @(negedge clk);
    chk("R8 edge pulse one clock", {31'd0, irq_line[12]}, 32'd0);
    do_read(3'd3, d, dn);
    chk("R8 no status", d, 32'd0);
  endtask

  task automatic t_legacy();
    logic [31:0] d, dn;
    do_write(3'd2, 32'd3);
    do_read(3'd2, d, dn);
    chk("R5 legacy bit capable", d, 32'd3);
    chk("R5 legacy bit reads zero", dn, 32'd1);
    ch_level[0] = 1'b0; ch_match[0] = 1'b1;
    @(negedge clk);
    ch_match[0] = 1'b0;
    chk("R9 ch0 on line 0", {31'd0, irq_line[0]}, 32'd1);
    chk("R9 ch0 route ignored", {31'd0, irq_line[3]}, 32'd0);
    chk("R5 no-legacy ch0 routed", {31'd0, irq_line_nc[3]}, 32'd1);
    chk("R5 no-legacy line 0", {31'd0, irq_line_nc[0]}, 32'd0);
    ch_level[1] = 1'b1; ch_match[1] = 1'b1;
    @(negedge clk);
    ch_match[1] = 1'b0;
    chk("R9 ch1 on line 8", {31'd0, irq_line[8]}, 32'd1);
    chk("R9 ch1 route ignored", {31'd0, irq_line[5]}, 32'd0);
    chk("R5 no-legacy ch1 routed", {31'd0, irq_line_nc[5]}, 32'd1);
    do_write(3'd3, 32'd2);
    chk("R9 lines idle after clear", {8'd0, irq_line}, 32'd0);
  endtask

  task automatic t_backpressure();
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd1;
    @(negedge clk);
    req_addr = 3'd2;
    chk("R10 stalled valid", {31'd0, rsp_valid}, 32'd1);
    chk("R10 stalled data", rsp_data, 32'h02FA_F080);
    chk("R10 ready low", {31'd0, req_ready}, 32'd0);
    idle(2);
    chk("R10 data held", rsp_data, 32'h02FA_F080);
    chk("R10 ready still low", {31'd0, req_ready}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 next read valid", {31'd0, rsp_valid}, 32'd1);
    chk("R10 next read data", rsp_data, 32'd3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_counter();
    t_level();
    t_edge();
    t_legacy();
    t_backpressure();
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule